// File: doc/BRIEF.md
# Sleep Control and Reset-Cause Flags

This block governs a processor core's power-down state and keeps the two status flags that firmware reads after start-up to learn why execution began again. The two flags are a time-out flag and a power-down flag. A sleep-instruction strobe puts the core to sleep. It also clears the external watchdog, which keeps counting while the core sleeps, and it stops the oscillator driver. Several things end sleep: a watchdog expiry, any enabled peripheral wake request, an external clear-reset, a brown-out or a power-on event. Each of these leaves the flag pair in its own pattern.

The block also exports a 3-bit code that names the last reset or wake event. That code holds until the next event arrives. When a wake-up happens in a crystal oscillator mode, the block raises a request for the oscillator start-up delay in the same cycle as its wake pulse, so that the reset sequencer can hold execution until the crystal is stable. Port registers are never touched by this block, so I/O levels stay as they were while the core sleeps.

Top module: `pslp_ctrl`

## Requirements
- R1: After synchronous reset, the outputs are as follows: the time-out flag is 1, the power-down flag is 1, the cause code is 0, the oscillator enable is 1, and the watchdog-clear, wake and start-up-delay pulses are all 0.
- R2: A sleep strobe while running sets the time-out flag to 1, clears the power-down flag and raises the watchdog clear for exactly one cycle. The oscillator enable then drops and stays low for as long as the core sleeps. The cause code is unchanged.
- R3: A clear-watchdog strobe while running sets both flags to 1 and raises the watchdog clear for one cycle. The cause code is unchanged.
- R4: A watchdog time-out while running clears the time-out flag, leaves the power-down flag at 1 and sets the cause code to 3. The code then holds during idle cycles.
- R5: A watchdog time-out while asleep clears the time-out flag, keeps the power-down flag at 0, sets the cause code to 4, pulses the wake request and re-enables the oscillator.
- R6: An external reset while running leaves both flags unchanged and sets the cause code to 1. While asleep, it leaves the flags as sleep entry left them (time-out 1, power-down 0), sets the code to 2 and ends sleep without a wake pulse.
- R7: A power-on event in either state sets both flags to 1, sets the cause code to 0, ends sleep and gives no wake pulse.
- R8: While asleep, any set bit of the wake-request vector ends sleep. The flags are left as they are, the cause code becomes 6 and the wake request pulses for one cycle. While running, the vector has no effect.
- R9: The start-up-delay request pulses together with the wake request only when the oscillator mode selects a crystal: codes 0, 1 and 2 are crystal modes, and code 3 is the RC mode.
- R10: Simultaneous events are resolved in this priority order: power-on, brown-out, external reset, watchdog time-out, peripheral wake, sleep, clear-watchdog. A brown-out sets both flags to 1 and sets the cause code to 5.
- R11: While asleep, sleep and clear-watchdog strobes have no effect: there is no watchdog clear, the flags do not change and the oscillator stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_stb | input | 1 | Sleep instruction executed |
| clrwdt_stb | input | 1 | Clear-watchdog instruction executed |
| wdt_timeout | input | 1 | Watchdog counter expired |
| wake_vec | input | WAKE_W | Masked peripheral wake requests |
| osc_mode | input | 2 | Oscillator mode (0..2 crystal, 3 RC) |
| por_evt | input | 1 | Power-on event |
| xrst_evt | input | 1 | External clear-reset event |
| bor_evt | input | 1 | Brown-out event |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| osc_drv_en | output | 1 | Oscillator driver enable |
| wdt_clr | output | 1 | One-cycle watchdog clear pulse |
| wake_req | output | 1 | One-cycle wake request to the reset sequencer |
| ost_req | output | 1 | Oscillator start-up delay request, with wake_req |
| rst_cause | output | 3 | Last reset or wake cause code |

## Verification
Every result is registered. The flags, the cause code and the oscillator enable take their new values at the first rising edge that sees the stimulus. The watchdog-clear, wake and start-up-delay pulses are high for exactly the cycle after that edge and low in the cycle after it. The bench changes inputs on the falling edge, holds them for one full cycle and reads the outputs on the falling edge that follows the capturing edge. Where a requirement calls for a one-cycle pulse or a held state, it reads again one falling edge later, or after several idle cycles.

// File: rtl/pslp_pkg.sv
package pslp_pkg;

    localparam int OSC_MODE_W = 2;
    localparam int CAUSE_W    = 3;

    typedef enum logic [OSC_MODE_W-1:0] {
        OSC_LP = 2'd0,
        OSC_XT = 2'd1,
        OSC_HS = 2'd2,
        OSC_RC = 2'd3
    } osc_mode_e;

    typedef enum logic [CAUSE_W-1:0] {
        CS_POR      = 3'd0,
        CS_XRST_RUN = 3'd1,
        CS_XRST_SLP = 3'd2,
        CS_WDT_RST  = 3'd3,
        CS_WDT_WAKE = 3'd4,
        CS_BOR      = 3'd5,
        CS_PWAKE    = 3'd6
    } cause_e;

    typedef enum logic [3:0] {
        EV_NONE,
        EV_POR,
        EV_BOR,
        EV_XRST_RUN,
        EV_XRST_SLP,
        EV_WDT_RST,
        EV_WDT_WAKE,
        EV_PWAKE,
        EV_SLEEP,
        EV_CLRWDT
    } evt_e;

    typedef struct packed {
        logic to;
        logic pd;
    } flags_t;

    typedef struct packed {
        logic   load;
        cause_e code;
    } cause_upd_t;

    localparam flags_t FLAGS_RESET = '{to: 1'b1, pd: 1'b1};

    // New flag pair for a classified event, given the present pair.
    function automatic flags_t next_flags(evt_e ev, flags_t cur);
        flags_t n;
        n = cur;
        unique case (ev)
            EV_POR, EV_BOR, EV_CLRWDT: n = '{to: 1'b1, pd: 1'b1};
            EV_SLEEP:                  n = '{to: 1'b1, pd: 1'b0};
            EV_WDT_RST:                n = '{to: 1'b0, pd: 1'b1};
            EV_WDT_WAKE:               n = '{to: 1'b0, pd: 1'b0};
            default:                   n = cur;
        endcase
        return n;
    endfunction

    // Cause code update; sleep and clear-watchdog leave it alone.
    function automatic cause_upd_t cause_of(evt_e ev);
        cause_upd_t u;
        u = '{load: 1'b1, code: CS_POR};
        unique case (ev)
            EV_POR:      u.code = CS_POR;
            EV_BOR:      u.code = CS_BOR;
            EV_XRST_RUN: u.code = CS_XRST_RUN;
            EV_XRST_SLP: u.code = CS_XRST_SLP;
            EV_WDT_RST:  u.code = CS_WDT_RST;
            EV_WDT_WAKE: u.code = CS_WDT_WAKE;
            EV_PWAKE:    u.code = CS_PWAKE;
            default:     u.load = 1'b0;
        endcase
        return u;
    endfunction

    function automatic logic ev_exits_sleep(evt_e ev);
        return (ev == EV_POR) || (ev == EV_BOR) || (ev == EV_XRST_SLP) ||
               (ev == EV_WDT_WAKE) || (ev == EV_PWAKE);
    endfunction

    function automatic logic ev_is_wake(evt_e ev);
        return (ev == EV_WDT_WAKE) || (ev == EV_PWAKE);
    endfunction

    function automatic logic ev_clears_wdt(evt_e ev);
        return (ev == EV_SLEEP) || (ev == EV_CLRWDT);
    endfunction

    function automatic logic osc_is_crystal(logic [OSC_MODE_W-1:0] mode);
        return osc_mode_e'(mode) != OSC_RC;
    endfunction

endpackage

// File: rtl/pslp_evt_decode.sv
module pslp_evt_decode
    import pslp_pkg::*;
#(
    parameter int WAKE_W = 8
) (
    input  logic              por_evt,
    input  logic              bor_evt,
    input  logic              xrst_evt,
    input  logic              wdt_timeout,
    input  logic [WAKE_W-1:0] wake_vec,
    input  logic              sleep_stb,
    input  logic              clrwdt_stb,
    input  logic              asleep,
    output evt_e              evt
);

    logic wake_any;

    assign wake_any = |wake_vec;

    // Fixed priority: supply events, external reset, watchdog,
    // peripheral wake (asleep only), then the two instruction strobes
    // (running only).
    always_comb begin
        evt = EV_NONE;
        if (por_evt) begin
            evt = EV_POR;
        end else if (bor_evt) begin
            evt = EV_BOR;
        end else if (xrst_evt) begin
            evt = asleep ? EV_XRST_SLP : EV_XRST_RUN;
        end else if (wdt_timeout) begin
            evt = asleep ? EV_WDT_WAKE : EV_WDT_RST;
        end else if (asleep) begin
            if (wake_any) begin
                evt = EV_PWAKE;
            end
        end else if (sleep_stb) begin
            evt = EV_SLEEP;
        end else if (clrwdt_stb) begin
            evt = EV_CLRWDT;
        end
    end

endmodule

// File: rtl/pslp_flag_unit.sv
module pslp_flag_unit
    import pslp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  evt_e   evt,
    output flags_t flags,
    output cause_e cause
);

    flags_t     flags_q;
    cause_e     cause_q;
    cause_upd_t upd;

    assign upd = cause_of(evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_RESET;
            cause_q <= CS_POR;
        end else begin
            flags_q <= next_flags(evt, flags_q);
            if (upd.load) begin
                cause_q <= upd.code;
            end
        end
    end

    assign flags = flags_q;
    assign cause = cause_q;

endmodule

// File: rtl/pslp_pwr_unit.sv
module pslp_pwr_unit
    import pslp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  evt_e                  evt,
    input  logic [OSC_MODE_W-1:0] osc_mode,
    output logic                  asleep,
    output logic                  wdt_clr,
    output logic                  wake_req,
    output logic                  ost_req
);

    logic asleep_q;
    logic wdt_clr_q;
    logic wake_q;
    logic ost_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep_q  <= 1'b0;
            wdt_clr_q <= 1'b0;
            wake_q    <= 1'b0;
            ost_q     <= 1'b0;
        end else begin
            wdt_clr_q <= ev_clears_wdt(evt);
            wake_q    <= ev_is_wake(evt);
            ost_q     <= ev_is_wake(evt) && osc_is_crystal(osc_mode);
            if (evt == EV_SLEEP) begin
                asleep_q <= 1'b1;
            end else if (ev_exits_sleep(evt)) begin
                asleep_q <= 1'b0;
            end
        end
    end

    assign asleep   = asleep_q;
    assign wdt_clr  = wdt_clr_q;
    assign wake_req = wake_q;
    assign ost_req  = ost_q;

endmodule

// File: rtl/pslp_ctrl.sv
module pslp_ctrl
    import pslp_pkg::*;
#(
    parameter int WAKE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_stb,
    input  logic              clrwdt_stb,
    input  logic              wdt_timeout,
    input  logic [WAKE_W-1:0] wake_vec,
    input  logic [1:0]        osc_mode,
    input  logic              por_evt,
    input  logic              xrst_evt,
    input  logic              bor_evt,
    output logic              to_flag,
    output logic              pd_flag,
    output logic              osc_drv_en,
    output logic              wdt_clr,
    output logic              wake_req,
    output logic              ost_req,
    output logic [2:0]        rst_cause
);

    evt_e   evt;
    flags_t flags;
    cause_e cause;
    logic   asleep;

    pslp_evt_decode #(.WAKE_W(WAKE_W)) u_decode (
        .por_evt    (por_evt),
        .bor_evt    (bor_evt),
        .xrst_evt   (xrst_evt),
        .wdt_timeout(wdt_timeout),
        .wake_vec   (wake_vec),
        .sleep_stb  (sleep_stb),
        .clrwdt_stb (clrwdt_stb),
        .asleep     (asleep),
        .evt        (evt)
    );

    pslp_flag_unit u_flags (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .flags(flags),
        .cause(cause)
    );

    pslp_pwr_unit u_pwr (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .osc_mode(osc_mode),
        .asleep  (asleep),
        .wdt_clr (wdt_clr),
        .wake_req(wake_req),
        .ost_req (ost_req)
    );

    assign to_flag    = flags.to;
    assign pd_flag    = flags.pd;
    assign rst_cause  = cause;
    assign osc_drv_en = ~asleep;

endmodule

// File: rtl/pslp_ctrl_chk.sv
module pslp_ctrl_chk #(
    parameter int WAKE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep_stb,
    input logic              clrwdt_stb,
    input logic              wdt_timeout,
    input logic [WAKE_W-1:0] wake_vec,
    input logic              por_evt,
    input logic              xrst_evt,
    input logic              bor_evt,
    input logic              to_flag,
    input logic              pd_flag,
    input logic              osc_drv_en,
    input logic              wdt_clr,
    input logic              wake_req,
    input logic              ost_req,
    input logic [2:0]        rst_cause
);

    logic hi_evt;
    assign hi_evt = por_evt | bor_evt | xrst_evt;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (to_flag && pd_flag && rst_cause == 3'd0 && osc_drv_en && !wdt_clr && !wake_req));

    p_sleep_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (osc_drv_en && sleep_stb && !hi_evt && !wdt_timeout)
        |=> (to_flag && !pd_flag && wdt_clr && !osc_drv_en));

    p_clrwdt_r3: assert property (@(posedge clk) disable iff (rst)
        (osc_drv_en && clrwdt_stb && !sleep_stb && !hi_evt && !wdt_timeout)
        |=> (to_flag && pd_flag && wdt_clr && osc_drv_en));

    p_wdt_run_r4: assert property (@(posedge clk) disable iff (rst)
        (osc_drv_en && wdt_timeout && !hi_evt)
        |=> (!to_flag && pd_flag && rst_cause == 3'd3));

    p_wdt_wake_r5: assert property (@(posedge clk) disable iff (rst)
        (!osc_drv_en && wdt_timeout && !hi_evt)
        |=> (!to_flag && !pd_flag && wake_req && osc_drv_en && rst_cause == 3'd4));

    p_xrst_run_r6: assert property (@(posedge clk) disable iff (rst)
        (osc_drv_en && xrst_evt && !por_evt && !bor_evt)
        |=> ($stable(to_flag) && $stable(pd_flag) && rst_cause == 3'd1));

    p_por_r7: assert property (@(posedge clk) disable iff (rst)
        por_evt |=> (to_flag && pd_flag && rst_cause == 3'd0 && osc_drv_en && !wake_req));

    p_pwake_run_r8: assert property (@(posedge clk) disable iff (rst)
        (osc_drv_en && (|wake_vec) && !hi_evt && !wdt_timeout) |=> !wake_req);

    p_ost_with_wake_r9: assert property (@(posedge clk) disable iff (rst)
        ost_req |-> wake_req);

    p_bor_r10: assert property (@(posedge clk) disable iff (rst)
        (bor_evt && !por_evt) |=> (rst_cause == 3'd5 && to_flag && pd_flag));

    p_strobe_asleep_r11: assert property (@(posedge clk) disable iff (rst)
        (!osc_drv_en && (sleep_stb || clrwdt_stb) && !hi_evt && !wdt_timeout && wake_vec == '0)
        |=> (!wdt_clr && !osc_drv_en && $stable(to_flag) && $stable(pd_flag)));

endmodule

bind pslp_ctrl pslp_ctrl_chk #(.WAKE_W(WAKE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep_stb  (sleep_stb),
    .clrwdt_stb (clrwdt_stb),
    .wdt_timeout(wdt_timeout),
    .wake_vec   (wake_vec),
    .por_evt    (por_evt),
    .xrst_evt   (xrst_evt),
    .bor_evt    (bor_evt),
    .to_flag    (to_flag),
    .pd_flag    (pd_flag),
    .osc_drv_en (osc_drv_en),
    .wdt_clr    (wdt_clr),
    .wake_req   (wake_req),
    .ost_req    (ost_req),
    .rst_cause  (rst_cause)
);

// File: tb/pslp_ctrl_bench.sv
`timescale 1ns/1ps
module pslp_ctrl_bench;

    localparam int WAKE_W = 8;
    localparam int NVEC   = 22;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sleep_stb = 1'b0;
    logic              clrwdt_stb = 1'b0;
    logic              wdt_timeout = 1'b0;
    logic [WAKE_W-1:0] wake_vec = '0;
    logic [1:0]        osc_mode = 2'd1;
    logic              por_evt = 1'b0;
    logic              xrst_evt = 1'b0;
    logic              bor_evt = 1'b0;
    logic              to_flag, pd_flag, osc_drv_en, wdt_clr, wake_req, ost_req;
    logic [2:0]        rst_cause;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pslp_ctrl #(.WAKE_W(WAKE_W)) u_pslp_ctrl (
        .clk(clk), .rst(rst), .sleep_stb(sleep_stb), .clrwdt_stb(clrwdt_stb),
        .wdt_timeout(wdt_timeout), .wake_vec(wake_vec), .osc_mode(osc_mode),
        .por_evt(por_evt), .xrst_evt(xrst_evt), .bor_evt(bor_evt),
        .to_flag(to_flag), .pd_flag(pd_flag), .osc_drv_en(osc_drv_en),
        .wdt_clr(wdt_clr), .wake_req(wake_req), .ost_req(ost_req),
        .rst_cause(rst_cause)
    );

    // Vector: prep[19:18] (0 fresh, 1 asleep, 2 after watchdog reset),
    // stim[17:11] {por,bor,xrst,wdt,pwake,sleep,clrwdt}, mode[10:9],
    // expected {to,pd,cause[2:0],osc,wdtclr,wake,ost}[8:0].
    localparam logic [19:0] VEC [NVEC] = '{
        {2'd0, 7'b1000000, 2'd1, 9'b11_000_1_000},  // R7
        {2'd1, 7'b1000000, 2'd1, 9'b11_000_1_000},  // R7
        {2'd0, 7'b0100000, 2'd1, 9'b11_101_1_000},  // R10 brown-out
        {2'd1, 7'b0100000, 2'd1, 9'b11_101_1_000},  // R10 brown-out
        {2'd2, 7'b0010000, 2'd1, 9'b01_001_1_000},  // R6 running
        {2'd1, 7'b0010000, 2'd1, 9'b10_010_1_000},  // R6 asleep
        {2'd0, 7'b0001000, 2'd1, 9'b01_011_1_000},  // R4
        {2'd1, 7'b0001000, 2'd1, 9'b00_100_1_011},  // R5
        {2'd1, 7'b0001000, 2'd3, 9'b00_100_1_010},  // R9 RC mode
        {2'd1, 7'b0000100, 2'd2, 9'b10_110_1_011},  // R8
        {2'd1, 7'b0000100, 2'd3, 9'b10_110_1_010},  // R9
        {2'd2, 7'b0000100, 2'd1, 9'b01_011_1_000},  // R8 running
        {2'd2, 7'b0000010, 2'd1, 9'b10_011_0_100},  // R2
        {2'd2, 7'b0000001, 2'd1, 9'b11_011_1_100},  // R3
        {2'd1, 7'b0000010, 2'd1, 9'b10_000_0_000},  // R11
        {2'd1, 7'b0000001, 2'd1, 9'b10_000_0_000},  // R11
        {2'd1, 7'b1111111, 2'd1, 9'b11_000_1_000},  // R10
        {2'd1, 7'b0111111, 2'd1, 9'b11_101_1_000},  // R10
        {2'd1, 7'b0011111, 2'd1, 9'b10_010_1_000},  // R10
        {2'd2, 7'b0001011, 2'd1, 9'b01_011_1_000},  // R10
        {2'd2, 7'b0000011, 2'd1, 9'b10_011_0_100},  // R10
        {2'd1, 7'b0001000, 2'd0, 9'b00_100_1_011}   // R9 LP mode
    };

    function automatic string req_of(int i);
        case (i)
            0, 1:          return "R7";
            2, 3:          return "R10";
            4, 5:          return "R6";
            6:             return "R4";
            7:             return "R5";
            8, 10, 21:     return "R9";
            9, 11:         return "R8";
            12:            return "R2";
            13:            return "R3";
            14, 15:        return "R11";
            default:       return "R10";
        endcase
    endfunction

    function automatic logic [8:0] observed();
        return {to_flag, pd_flag, rst_cause, osc_drv_en, wdt_clr, wake_req, ost_req};
    endfunction

    task automatic check(string req, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic quiet();
        {por_evt, bor_evt, xrst_evt, wdt_timeout, sleep_stb, clrwdt_stb} = '0;
        wake_vec = '0;
    endtask

    task automatic drive(logic [6:0] s, int bit_idx);
        {por_evt, bor_evt, xrst_evt, wdt_timeout} = s[6:3];
        wake_vec = s[2] ? (WAKE_W'(1) << bit_idx) : '0;
        sleep_stb  = s[1];
        clrwdt_stb = s[0];
    endtask

    task automatic do_reset();
        quiet();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse(logic [6:0] s, int bit_idx);
        drive(s, bit_idx);
        @(negedge clk);
        quiet();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1", observed(), 9'b11_000_1_000);

        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            osc_mode = VEC[i][10:9];
            if (VEC[i][19:18] == 2'd1) pulse(7'b0000010, 0);
            else if (VEC[i][19:18] == 2'd2) pulse(7'b0001000, 0);
            pulse(VEC[i][17:11], i % WAKE_W);
            check(req_of(i), observed(), VEC[i][8:0]);
        end

        // R2: watchdog clear lasts one cycle, oscillator stays off while asleep
        do_reset();
        pulse(7'b0000010, 0);
        check_bit("R2", wdt_clr, 1'b1);
        @(negedge clk);
        check_bit("R2", wdt_clr, 1'b0);
        repeat (5) @(negedge clk);
        check("R2", observed(), 9'b10_000_0_000);

        // R8: all-zero wake vector while asleep changes nothing
        check_bit("R8", osc_drv_en, 1'b0);

        // R8: top wake bit ends sleep; wake pulse lasts one cycle
        osc_mode = 2'd0;
        pulse(7'b0000100, WAKE_W - 1);
        check("R8", observed(), 9'b10_110_1_011);
        @(negedge clk);
        check_bit("R8", wake_req, 1'b0);

        // R4: cause code holds through idle cycles
        do_reset();
        pulse(7'b0001000, 0);
        repeat (10) @(negedge clk);
        check("R4", observed(), 9'b01_011_1_000);

        // R3: clear-watchdog restores the time-out flag after a watchdog reset
        pulse(7'b0000001, 0);
        check("R3", observed(), 9'b11_011_1_100);

        summary();
        $finish;
    end

endmodule